// File: doc/BRIEF.md
# Floating-Point Issue Latency Scoreboard

This block decides, cycle by cycle, whether the next floating-point operation may issue. The execution side it watches has two units that run side by side. One is a pipelined unit for adds, multiplies, conversions and the one-cycle moves. The other is an iterative unit for divide, square root and the reciprocal forms. Each incoming operation brings an opcode, a precision bit, three source register tags and a destination tag. The scoreboard holds the operation back in four cases: its unit has not yet recovered from its repeat interval, a source or the destination still waits on a result, or its completion would land on the same cycle as an earlier result from the same unit.

Every accepted operation loads a countdown for its destination register. The block reports, per unit, the cycle on which each result becomes available, together with the destination tag. The issue side uses a valid/ready handshake. `iss_ready` depends only on the operation presented and the current state, never on `iss_valid`.

Top module: `fp_issue_scoreboard`

## Requirements
- R1: Add (op 0), subtract (op 1) and the general format conversion (op 10) have latency 4 and repeat interval 1 in both precisions (`iss_dbl` 0 = single, 1 = double).
- R2: Multiply (op 2), multiply-add (op 3) and multiply-subtract (op 4) have latency 4 and repeat 1 in single, and latency 5 and repeat 2 in double.
- R3: Divide (op 5), square root (op 6) and reciprocal (op 7) run on the iterative unit, with latency 21 and repeat 19 in single, and latency 36 and repeat 34 in double.
- R4: Reciprocal square root (op 8) runs on the iterative unit, with latency 38 and repeat 36 in single, and latency 68 and repeat 66 in double.
- R5: Integer-to-single conversion (op 9) has latency 6 and repeat 3, whatever the value of `iss_dbl`.
- R6: Compare (11), move (12), conditional move (13), absolute value (14) and negate (15) have latency 1 and repeat 1.
- R7: An operation in flight on the iterative unit does not delay issue on the pipelined unit.
- R8: While any of the three sources or the destination has a result still pending, `iss_ready` stays low. It rises in the cycle that result is reported.
- R9: An operation whose completion would coincide with a pending completion on the same unit is stalled, so each unit reports at most one result per cycle.
- R10: A synchronous reset clears every pending result and frees both units. No result from before the reset is reported afterwards.
- R11: An operation accepted in cycle t (valid and ready both high) is reported in cycle t+L with its destination tag, where L is its latency. Pipelined results appear on `pipe_done`/`pipe_done_tag` and iterative results on `iter_done`/`iter_done_tag`. Repeat interval R means the next operation for the same unit is accepted no earlier than cycle t+R.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| iss_valid | input | 1 | An operation is presented |
| iss_ready | output | 1 | The presented operation may issue this cycle |
| iss_op | input | 4 | Opcode, encoded as in R1 to R6 |
| iss_dbl | input | 1 | Precision: 1 = double |
| iss_src_a | input | TAG_W | First source register tag |
| iss_src_b | input | TAG_W | Second source register tag |
| iss_src_c | input | TAG_W | Third source register tag |
| iss_dst | input | TAG_W | Destination register tag |
| pipe_done | output | 1 | A pipelined-unit result is available this cycle |
| pipe_done_tag | output | TAG_W | Destination tag of that result |
| iter_done | output | 1 | An iterative-unit result is available this cycle |
| iter_done_tag | output | TAG_W | Destination tag of that result |

## Verification
The bench sweeps all sixteen opcodes in both precisions. For each pair it measures the accepted-to-accepted gap and both completion cycles, so a wrong entry in either table shows up as an early or late issue or a misplaced done pulse. Directed cases cover four further faults: a divide left blocking the adder, a dependent add released one cycle early or late, a compare that retires on top of an add, and a reset that leaves a stale countdown behind. A design with the last fault would either stall the dependent add or later raise a done pulse for a tag that no longer exists.

// File: rtl/fpsb_pkg.sv
package fpsb_pkg;

  localparam int LAT_W = 7;

  typedef enum logic [3:0] {
    OP_ADD, OP_SUB, OP_MUL, OP_MADD, OP_MSUB,
    OP_DIV, OP_SQRT, OP_RECIP, OP_RSQRT,
    OP_CVT_I2S, OP_CVT, OP_CMP, OP_MOV, OP_CMOV, OP_ABS, OP_NEG
  } fp_op_e;

  // 1 = iterative divide/root unit, 0 = pipelined unit
  function automatic logic is_iter(fp_op_e op);
    return (op == OP_DIV) || (op == OP_SQRT) || (op == OP_RECIP) || (op == OP_RSQRT);
  endfunction

  function automatic logic [LAT_W-1:0] op_latency(fp_op_e op, logic dbl);
    case (op)
      OP_MUL, OP_MADD, OP_MSUB:  return dbl ? 7'd5 : 7'd4;
      OP_DIV, OP_SQRT, OP_RECIP: return dbl ? 7'd36 : 7'd21;
      OP_RSQRT:                  return dbl ? 7'd68 : 7'd38;
      OP_CVT_I2S:                return 7'd6;
      OP_CMP, OP_MOV, OP_CMOV, OP_ABS, OP_NEG: return 7'd1;
      default:                   return 7'd4;
    endcase
  endfunction

  function automatic logic [LAT_W-1:0] op_repeat(fp_op_e op, logic dbl);
    case (op)
      OP_MUL, OP_MADD, OP_MSUB:  return dbl ? 7'd2 : 7'd1;
      OP_DIV, OP_SQRT, OP_RECIP: return dbl ? 7'd34 : 7'd19;
      OP_RSQRT:                  return dbl ? 7'd66 : 7'd36;
      OP_CVT_I2S:                return 7'd3;
      default:                   return 7'd1;
    endcase
  endfunction

endpackage

// File: rtl/fpsb_rate_gate.sv
module fpsb_rate_gate #(
  parameter int CW = 7
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          fire,
  input  logic [CW-1:0] rep,
  output logic          free_o
);

  logic [CW-1:0] busy_q;

  always_ff @(posedge clk) begin
    if (rst)                busy_q <= '0;
    else if (fire)          busy_q <= rep - CW'(1);
    else if (busy_q != '0)  busy_q <= busy_q - CW'(1);
  end

  assign free_o = (busy_q == '0);

  // R3: a repeat interval above one blocks the unit on the following cycle
  a_r3_rate_hold: assert property (@(posedge clk) disable iff (rst)
    (fire && rep > 1) |=> !free_o);

  // R6: a single-cycle repeat leaves the unit free on the following cycle
  a_r6_rate_free: assert property (@(posedge clk) disable iff (rst)
    (fire && rep == 1) |=> free_o);

endmodule

// File: rtl/fpsb_regtrack.sv
module fpsb_regtrack #(
  parameter int NREG  = 32,
  parameter int CW    = 7,
  parameter int TAG_W = $clog2(NREG)
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     set,
  input  logic [TAG_W-1:0]         set_tag,
  input  logic [CW-1:0]            set_lat,
  input  logic                     set_unit,
  output logic [NREG-1:0]          pend_o,
  output logic [NREG-1:0]          unit_o,
  output logic [NREG-1:0]          done_o,
  output logic [NREG-1:0][CW-1:0]  cnt_o
);

  for (genvar r = 0; r < NREG; r++) begin : g_reg
    logic [CW-1:0] cnt_q;
    logic          unit_q, done_q;
    logic          hit;

    assign hit = set && (set_tag == TAG_W'(r));

    always_ff @(posedge clk) begin
      if (rst) begin
        cnt_q  <= '0;
        unit_q <= 1'b0;
        done_q <= 1'b0;
      end else begin
        done_q <= (hit && set_lat == CW'(1)) || (cnt_q == CW'(1));
        if (hit) begin
          cnt_q  <= set_lat - CW'(1);
          unit_q <= set_unit;
        end else if (cnt_q != '0) begin
          cnt_q <= cnt_q - CW'(1);
        end
      end
    end

    assign pend_o[r] = (cnt_q != '0);
    assign unit_o[r] = unit_q;
    assign done_o[r] = done_q;
    assign cnt_o[r]  = cnt_q;

    // R10: the first cycle after reset holds nothing pending
    a_r10_clear: assert property (@(posedge clk) rst |=> !pend_o[r] && !done_o[r]);
  end

endmodule

// File: rtl/fp_issue_scoreboard.sv
module fp_issue_scoreboard
  import fpsb_pkg::*;
#(
  parameter int NREG  = 32,
  parameter int TAG_W = $clog2(NREG)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             iss_valid,
  output logic             iss_ready,
  input  logic [3:0]       iss_op,
  input  logic             iss_dbl,
  input  logic [TAG_W-1:0] iss_src_a,
  input  logic [TAG_W-1:0] iss_src_b,
  input  logic [TAG_W-1:0] iss_src_c,
  input  logic [TAG_W-1:0] iss_dst,
  output logic             pipe_done,
  output logic [TAG_W-1:0] pipe_done_tag,
  output logic             iter_done,
  output logic [TAG_W-1:0] iter_done_tag
);

  localparam int NUNIT = 2;

  fp_op_e                      op;
  logic                        new_unit;
  logic [LAT_W-1:0]            new_lat, new_rep;
  logic [NREG-1:0]             pend, unit_q, done_q;
  logic [NREG-1:0][LAT_W-1:0]  cnt_q;
  logic [NUNIT-1:0]            unit_free;
  logic                        haz_src, haz_dst, haz_slot, iss_fire;
  logic [NREG-1:0]             pipe_vec, iter_vec;

  assign op       = fp_op_e'(iss_op);
  assign new_unit = is_iter(op);
  assign new_lat  = op_latency(op, iss_dbl);
  assign new_rep  = op_repeat(op, iss_dbl);

  assign haz_src = pend[iss_src_a] || pend[iss_src_b] || pend[iss_src_c];
  assign haz_dst = pend[iss_dst];

  // a pending entry on the same unit that would retire on the new op's cycle
  always_comb begin
    haz_slot = 1'b0;
    for (int r = 0; r < NREG; r++)
      if (pend[r] && unit_q[r] == new_unit && cnt_q[r] == new_lat)
        haz_slot = 1'b1;
  end

  assign iss_ready = !haz_src && !haz_dst && !haz_slot && unit_free[new_unit];
  assign iss_fire  = iss_valid && iss_ready;

  for (genvar u = 0; u < NUNIT; u++) begin : g_unit
    fpsb_rate_gate #(.CW(LAT_W)) u_gate (
      .clk    (clk),
      .rst    (rst),
      .fire   (iss_fire && (new_unit == 1'(u))),
      .rep    (new_rep),
      .free_o (unit_free[u])
    );
  end

  fpsb_regtrack #(.NREG(NREG), .CW(LAT_W), .TAG_W(TAG_W)) u_track (
    .clk      (clk),
    .rst      (rst),
    .set      (iss_fire),
    .set_tag  (iss_dst),
    .set_lat  (new_lat),
    .set_unit (new_unit),
    .pend_o   (pend),
    .unit_o   (unit_q),
    .done_o   (done_q),
    .cnt_o    (cnt_q)
  );

  function automatic logic [TAG_W-1:0] vec_to_tag(logic [NREG-1:0] v);
    logic [TAG_W-1:0] t;
    t = '0;
    for (int i = 0; i < NREG; i++)
      if (v[i]) t = TAG_W'(i);
    return t;
  endfunction

  assign pipe_vec      = done_q & ~unit_q;
  assign iter_vec      = done_q & unit_q;
  assign pipe_done     = |pipe_vec;
  assign iter_done     = |iter_vec;
  assign pipe_done_tag = vec_to_tag(pipe_vec);
  assign iter_done_tag = vec_to_tag(iter_vec);

  // R9: at most one completion per unit in any cycle
  a_r9_pipe_single: assert property (@(posedge clk) disable iff (rst) $onehot0(pipe_vec));
  a_r9_iter_single: assert property (@(posedge clk) disable iff (rst) $onehot0(iter_vec));

  // R11: a reported tag no longer counts as pending
  a_r11_pipe_released: assert property (@(posedge clk) disable iff (rst)
    pipe_done |-> !pend[pipe_done_tag]);
  a_r11_iter_released: assert property (@(posedge clk) disable iff (rst)
    iter_done |-> !pend[iter_done_tag]);

  // R8: a pending source never lets an operation through
  a_r8_src_block: assert property (@(posedge clk) disable iff (rst)
    (iss_valid && pend[iss_src_a]) |-> !iss_ready);

endmodule

// File: tb/fp_issue_scoreboard_bench.sv
module fp_issue_scoreboard_bench;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       iss_valid = 1'b0;
  logic       iss_ready;
  logic [3:0] iss_op = '0;
  logic       iss_dbl = 1'b0;
  logic [4:0] iss_src_a = '0, iss_src_b = '0, iss_src_c = '0, iss_dst = '0;
  logic       pipe_done, iter_done;
  logic [4:0] pipe_done_tag, iter_done_tag;

  fp_issue_scoreboard u_fp_issue_scoreboard (
    .clk(clk), .rst(rst), .iss_valid(iss_valid), .iss_ready(iss_ready),
    .iss_op(iss_op), .iss_dbl(iss_dbl), .iss_src_a(iss_src_a),
    .iss_src_b(iss_src_b), .iss_src_c(iss_src_c), .iss_dst(iss_dst),
    .pipe_done(pipe_done), .pipe_done_tag(pipe_done_tag),
    .iter_done(iter_done), .iter_done_tag(iter_done_tag)
  );

  always #10 clk = ~clk;

  int cyc = 0;
  int errors = 0;
  int checks = 0;
  int done_at [32];
  int done_cnt [32];

  int lat_s [16] = '{4,4,4,4,4,21,21,21,38,6,4,1,1,1,1,1};
  int lat_d [16] = '{4,4,5,5,5,36,36,36,68,6,4,1,1,1,1,1};
  int rep_s [16] = '{1,1,1,1,1,19,19,19,36,3,1,1,1,1,1,1};
  int rep_d [16] = '{1,1,2,2,2,34,34,34,66,3,1,1,1,1,1,1};

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (pipe_done) begin done_at[pipe_done_tag] = cyc; done_cnt[pipe_done_tag]++; end
    if (iter_done) begin done_at[iter_done_tag] = cyc; done_cnt[iter_done_tag]++; end
  end

  task automatic summary_and_end();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  always @(posedge clk) if (cyc > 190000) begin
    errors++;
    $display("FAIL watchdog: actual cycle %0d expected completion before 190000", cyc);
    summary_and_end();
  end

  task automatic check_eq(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic string req_of(int op);
    if (op == 0 || op == 1 || op == 10) return "R1";
    if (op >= 2 && op <= 4) return "R2";
    if (op >= 5 && op <= 7) return "R3";
    if (op == 8) return "R4";
    if (op == 9) return "R5";
    return "R6";
  endfunction

  task automatic clear_log();
    for (int i = 0; i < 32; i++) begin done_at[i] = -1; done_cnt[i] = 0; end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; iss_valid = 1'b0;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    clear_log();
  endtask

  // present an operation until accepted; t = cycle of acceptance
  task automatic issue(int op, int dbl, int sa, int sb, int sc, int dst, output int t);
    int n;
    @(negedge clk);
    iss_op = 4'(op); iss_dbl = 1'(dbl);
    iss_src_a = 5'(sa); iss_src_b = 5'(sb); iss_src_c = 5'(sc); iss_dst = 5'(dst);
    iss_valid = 1'b1;
    n = 0;
    #1;
    while (!iss_ready && n < 1000) begin
      @(negedge clk); #1; n++;
    end
    if (n >= 1000) begin
      errors++;
      $display("FAIL stall: actual never ready expected acceptance (op %0d)", op);
    end
    t = cyc;
    @(posedge clk); #1;
    iss_valid = 1'b0;
  endtask

  task automatic wait_until(int c);
    while (cyc < c) @(negedge clk);
  endtask

  initial begin
    int t0, t1, t2, t3, t4, t5, lat, rep, c0;
    clear_log();
    do_reset();

    // R10: reset state
    check_eq("R10 pipe_done after reset", int'(pipe_done), 0);
    check_eq("R10 iter_done after reset", int'(iter_done), 0);
    iss_op = 4'd5; iss_dbl = 1'b1; iss_valid = 1'b1; #1;
    check_eq("R10 ready after reset", int'(iss_ready), 1);
    iss_valid = 1'b0;

    // R1..R6, R11: sweep every opcode in both precisions
    for (int op = 0; op < 16; op++) begin
      for (int dbl = 0; dbl < 2; dbl++) begin
        do_reset();
        lat = dbl ? lat_d[op] : lat_s[op];
        rep = dbl ? rep_d[op] : rep_s[op];
        issue(op, dbl, 0, 0, 0, 1, t0);
        issue(op, dbl, 0, 0, 0, 2, t1);
        check_eq($sformatf("%s repeat op%0d dbl%0d", req_of(op), op, dbl), t1 - t0, rep);
        wait_until(t1 + lat + 2);
        check_eq($sformatf("%s R11 latency first op%0d dbl%0d", req_of(op), op, dbl), done_at[1], t0 + lat);
        check_eq($sformatf("%s R11 latency second op%0d dbl%0d", req_of(op), op, dbl), done_at[2], t1 + lat);
        check_eq($sformatf("R11 single pulse op%0d dbl%0d", op, dbl), done_cnt[1], 1);
      end
    end

    // R7: double divide in flight, add issues the next cycle
    do_reset();
    issue(5, 1, 0, 0, 0, 3, t0);
    issue(0, 0, 0, 0, 0, 4, t1);
    check_eq("R7 add not blocked by divide", t1, t0 + 1);
    wait_until(t0 + 40);
    check_eq("R7 add result", done_at[4], t1 + 4);
    check_eq("R7 divide result", done_at[3], t0 + 36);

    // R8: source and destination hazards
    do_reset();
    issue(5, 0, 0, 0, 0, 5, t0);
    issue(0, 0, 5, 0, 0, 6, t1);
    check_eq("R8 add waits on divide source", t1, t0 + 21);
    issue(2, 1, 0, 0, 0, 7, t2);
    issue(3, 1, 0, 0, 7, 8, t3);
    check_eq("R8 madd waits on third source", t3, t2 + 5);
    issue(6, 0, 0, 0, 0, 9, t4);
    issue(0, 0, 0, 0, 0, 9, t5);
    check_eq("R8 destination hazard", t5, t4 + 21);
    wait_until(t5 + 6);
    check_eq("R8 rewritten destination result", done_at[9], t5 + 4);
    check_eq("R8 rewritten destination pulses", done_cnt[9], 2);

    // R9: compare would retire on the add's cycle
    do_reset();
    issue(0, 0, 0, 0, 0, 10, t0);
    repeat (2) @(negedge clk);
    issue(11, 0, 0, 0, 0, 11, t1);
    check_eq("R9 compare stalled one cycle", t1, t0 + 4);
    wait_until(t1 + 3);
    check_eq("R9 add result", done_at[10], t0 + 4);
    check_eq("R9 compare result", done_at[11], t0 + 5);

    // R10: reset mid-flight discards the pending root
    do_reset();
    issue(8, 1, 0, 0, 0, 12, t0);
    repeat (5) @(negedge clk);
    do_reset();
    c0 = cyc;
    issue(0, 0, 12, 0, 0, 13, t1);
    check_eq("R10 dependent add free after reset", t1, c0 + 1);
    issue(7, 1, 0, 0, 0, 14, t2);
    check_eq("R10 iterative unit free after reset", t2, t1 + 1);
    wait_until(t0 + 90);
    check_eq("R10 stale result suppressed", done_cnt[12], 0);

    summary_and_end();
  end

endmodule